// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block performs signed 32-bit multiplication and division over several cycles and places the results in two dedicated result registers, HI and LO, instead of a register file. A caller raises `start` for one cycle with two operands and an operation select. The unit then raises `busy` for a fixed number of cycles. When it finishes, it loads HI and LO together and pulses `done`.

A multiply splits its 64-bit product across the pair. A divide puts the quotient in LO and the remainder in HI, so a modulo is obtained by dividing and then reading HI. The stored values are read at any time through the two move-from outputs. Multiply uses iterative shift-and-add on operand magnitudes. Divide uses restoring long division. A final sign correction is applied to both.

Top module: `muldiv_unit`

## Requirements
- R1: With `opSel` = 0 (multiply), LO receives bits 31..0 and HI receives bits 63..32 of the signed two's-complement 64-bit product of `srcA` and `srcB`.
- R2: With `opSel` = 1 (divide) and a nonzero divisor, LO receives the signed quotient `srcA`/`srcB`, truncated toward zero. HI receives the remainder, which carries the sign of the dividend `srcA`.
- R3: A divide by zero completes normally with no trap. It leaves LO = 0xFFFFFFFF and HI = the dividend `srcA`.
- R4: Dividing 0x80000000 by 0xFFFFFFFF (minus one) yields LO = 0x80000000 and HI = 0.
- R5: A `start` raised while `busy` is high is ignored. It does not change the running operation's result or timing, and it produces no extra `done`. The operands and `opSel` are sampled only at the edge that accepts a start.
- R6: A start is accepted at a rising edge where `busy` is low. `busy` is then high for exactly the 32 cycles that follow. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R7: HI and LO hold their values in every cycle except the one in which `done` is high. In that cycle both take their new values together.
- R8: While `rstN` is low, and in the first cycle after reset, `busy`, `done`, HI and LO are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| opSel | input | 1 | Operation select: 0 = signed multiply, 1 = signed divide |
| srcA | input | 32 | First operand (multiplicand or dividend) |
| srcB | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; HI/LO are new in this cycle |
| hiOut | output | 32 | Move-from-HI read port |
| loOut | output | 32 | Move-from-LO read port |

## Verification
The embedded properties watch the timing on every cycle:
- `busy` stays high until the final step.
- `done` is a single pulse that immediately follows `busy`, and `busy` rises only after an accepted start.
- HI and LO move only in the `done` cycle.
- A multiply by zero clears the pair.
- A divide remainder is always smaller in magnitude than the divisor.

The arithmetic values themselves can only be shown by the bench's scenarios. These cover mixed sign combinations, the largest magnitudes, division by zero, the one overflowing quotient, and a start with changed operands issued in mid-run.

// File: rtl/md_pkg.sv
package md_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mdOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, clear working state
    logic step;    // perform one iteration
    logic commit;  // final iteration: write HI/LO
  } mdCtrl_t;

endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import md_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mdCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctrl.load   = start && !busy;
    ctrl.step   = busy;
    ctrl.commit = busy && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= ctrl.commit;
      if (ctrl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (ctrl.commit) begin
        busy    <= 1'b0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // R5: a running operation is never cut short, start or not
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctrl.commit) |=> busy);

  // R6: busy rises only after a start request
  a_r6_rise_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R6: done directly follows the busy window
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/md_dpath.sv
module md_dpath
  import md_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdCtrl_t          ctrl,
  input  mdOp_e            opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] hiReg,
  output logic [WIDTH-1:0] loReg
);

  localparam int DW = 2 * WIDTH;

  // Working state: workHi is accumulator / partial remainder,
  // workLo is multiplier / dividend-then-quotient
  logic [WIDTH-1:0] workHi, workLo, magB;
  logic             isDiv, negMain, negRem, divZero;

  logic [WIDTH-1:0] magA, magBIn;
  logic             signA, signB;

  logic [WIDTH:0]   mulSum;
  logic [WIDTH:0]   divShift;
  logic [WIDTH+1:0] divDiff;
  logic             divFits;
  logic [WIDTH-1:0] nextHi, nextLo;

  logic [DW-1:0]    prodRaw, prodFix;
  logic [WIDTH-1:0] quoFix, remFix, resHi, resLo;

  // Operand magnitudes (the most negative value maps to itself, unsigned)
  always_comb begin
    signA  = srcA[WIDTH-1];
    signB  = srcB[WIDTH-1];
    magA   = signA ? (~srcA + 1'b1) : srcA;
    magBIn = signB ? (~srcB + 1'b1) : srcB;
  end

  // One iteration of either algorithm
  always_comb begin
    mulSum   = {1'b0, workHi} + {1'b0, (workLo[0] ? magB : {WIDTH{1'b0}})};
    divShift = {workHi, workLo[WIDTH-1]};
    divDiff  = {1'b0, divShift} - {2'b00, magB};
    divFits  = !divDiff[WIDTH+1];
    if (isDiv) begin
      nextHi = divFits ? divDiff[WIDTH-1:0] : divShift[WIDTH-1:0];
      nextLo = {workLo[WIDTH-2:0], divFits};
    end else begin
      nextHi = mulSum[WIDTH:1];
      nextLo = {mulSum[0], workLo[WIDTH-1:1]};
    end
  end

  // Sign correction and result selection
  always_comb begin
    prodRaw = {nextHi, nextLo};
    prodFix = negMain ? (~prodRaw + 1'b1) : prodRaw;
    quoFix  = negMain ? (~nextLo + 1'b1) : nextLo;
    remFix  = negRem  ? (~nextHi + 1'b1) : nextHi;
    if (!isDiv) begin
      resHi = prodFix[DW-1:WIDTH];
      resLo = prodFix[WIDTH-1:0];
    end else if (divZero) begin
      resHi = remFix;
      resLo = {WIDTH{1'b1}};
    end else begin
      resHi = remFix;
      resLo = quoFix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workHi  <= '0;
      workLo  <= '0;
      magB    <= '0;
      isDiv   <= 1'b0;
      negMain <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
      hiReg   <= '0;
      loReg   <= '0;
    end else if (ctrl.load) begin
      workHi  <= '0;
      workLo  <= magA;
      magB    <= magBIn;
      isDiv   <= (opSel == OP_DIV);
      negMain <= signA ^ signB;
      negRem  <= signA;
      divZero <= (srcB == '0);
    end else if (ctrl.step) begin
      workHi <= nextHi;
      workLo <= nextLo;
      if (ctrl.commit) begin
        hiReg <= resHi;
        loReg <= resLo;
      end
    end
  end

  // R2: the remainder magnitude always ends below the divisor magnitude
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit && isDiv && !divZero) |-> (nextHi < magB));

  // R1: a product with a zero multiplier clears both halves
  a_r1_mul_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commit && !isDiv && (magB == '0)) |=> (hiReg == '0 && loReg == '0));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import md_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  mdCtrl_t ctrl;

  md_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrl),
    .busy (busy),
    .done (done)
  );

  md_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl),
    .opSel(mdOp_e'(opSel)),
    .srcA (srcA),
    .srcB (srcB),
    .hiReg(hiOut),
    .loReg(loOut)
  );

  // R7: the result pair changes only in the done cycle
  a_r7_hold_pair: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hiOut) && $stable(loOut)));

endmodule

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opSel = 1'b0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    string       req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;

  function automatic void check(input bit ok, input string req, input string what,
                                input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic op, input logic [31:0] a, input logic [31:0] b,
                                 input string req);
    exp_t   e;
    int     ia, ib;
    longint p;
    e.req = req;
    ia = a;
    ib = b;
    if (!op) begin                       // R1
      p = longint'(ia) * longint'(ib);
      e.hi = p[63:32];
      e.lo = p[31:0];
    end else if (b == 32'h0) begin       // R3
      e.lo = 32'hFFFF_FFFF;
      e.hi = a;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin  // R4
      e.lo = 32'h8000_0000;
      e.hi = 32'h0;
    end else begin                       // R2
      e.lo = ia / ib;
      e.hi = ia % ib;
    end
    return e;
  endfunction

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "done without a pending operation", {63'h0, done}, 64'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(hiOut == e.hi && loOut == e.lo, e.req, "result {hi,lo}",
              {hiOut, loOut}, {e.hi, e.lo});
      end
    end
  end

  // Driver: issue one operation, check the busy window, hold and done pulse
  task automatic runOp(input logic op, input logic [31:0] a, input logic [31:0] b,
                       input string req, input bit poke);
    logic [31:0] oldHi, oldLo;
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    oldHi = hiOut;
    oldLo = loOut;
    start = 1'b1;
    opSel = op;
    srcA  = a;
    srcB  = b;
    expQ.push_back(model(op, a, b, req));
    @(negedge clk);
    start = 1'b0;
    check(busy, "R6", "busy after accepted start", {63'h0, busy}, 64'h1);
    n = 0;
    while (busy && n < 40) begin
      n++;
      check(hiOut == oldHi && loOut == oldLo, "R7", "pair held while busy",
            {hiOut, loOut}, {oldHi, oldLo});
      if (poke && n == 5) begin
        // R5: start with different operands and op while busy
        start = 1'b1;
        opSel = ~op;
        srcA  = ~a;
        srcB  = 32'h0000_0003;
      end else if (poke && n == 6) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    check(n == 32, req == "R5" ? "R5" : "R6", "busy cycle count", 64'(n), 64'd32);
    check(done, "R6", "done in first non-busy cycle", {63'h0, done}, 64'h1);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!busy && !done, "R8", "busy/done in reset", {62'h0, busy, done}, 64'h0);
    check(hiOut == 0 && loOut == 0, "R8", "pair in reset", {hiOut, loOut}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && hiOut == 0 && loOut == 0, "R8", "state after reset",
          {hiOut, loOut}, 64'h0);

    // R1: multiply
    runOp(1'b0, 32'd7,          32'd6,          "R1", 1'b0);
    runOp(1'b0, 32'hFFFF_FFFD,  32'd5,          "R1", 1'b0);
    runOp(1'b0, 32'h7FFF_FFFF,  32'h7FFF_FFFF,  "R1", 1'b0);
    runOp(1'b0, 32'h8000_0000,  32'h8000_0000,  "R1", 1'b0);
    runOp(1'b0, 32'h8000_0000,  32'h7FFF_FFFF,  "R1", 1'b0);
    runOp(1'b0, 32'h1234_5678,  32'h0,          "R1", 1'b0);
    runOp(1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  "R1", 1'b0);

    // R2: divide, all sign combinations and a small dividend
    runOp(1'b1, 32'd100,        32'd7,          "R2", 1'b0);
    runOp(1'b1, -32'sd100,      32'd7,          "R2", 1'b0);
    runOp(1'b1, 32'd100,        -32'sd7,        "R2", 1'b0);
    runOp(1'b1, -32'sd100,      -32'sd7,        "R2", 1'b0);
    runOp(1'b1, 32'd3,          32'd10,         "R2", 1'b0);
    runOp(1'b1, 32'h7FFF_FFFF,  32'd1,          "R2", 1'b0);
    runOp(1'b1, 32'h8000_0000,  32'd3,          "R2", 1'b0);

    // R3: divide by zero
    runOp(1'b1, 32'd5,          32'h0,          "R3", 1'b0);
    runOp(1'b1, -32'sd5,        32'h0,          "R3", 1'b0);

    // R4: the overflowing quotient
    runOp(1'b1, 32'h8000_0000,  32'hFFFF_FFFF,  "R4", 1'b0);

    // R5: start while busy, with changed operands
    runOp(1'b0, 32'hDEAD_BEEF,  32'h0000_1001,  "R5", 1'b1);
    runOp(1'b1, -32'sd77,       32'd8,          "R5", 1'b1);

    // R5: no stray completion afterwards
    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R5", "scoreboard drained", 64'(expQ.size()), 64'h0);
    check(!busy, "R5", "idle after ignored starts", {63'h0, busy}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule